// File: doc/BRIEF.md
# MDIO Paged Register Bridge

This block is a clause-22 MDIO management slave that opens a 32-bit internal register space to an MDIO host. The 5-bit PHY address field of every frame is not a plain device address here. Its two upper bits pick an access mode. Its three lower bits are either more register-address bits or the index of a real PHY that sits behind the bridge. A page register, loaded by a dedicated frame type, supplies the upper register-address bits. Two 16-bit MDIO transfers, low half first and then high half, make up one 32-bit register access.

The bridge oversamples MDC and MDIO with the system clock. A write of a low half is kept in a staging register. The whole 32-bit word goes to the internal register port only when the matching high half arrives. A read of a low half fetches the full word once and keeps the upper 16 bits, so the high-half read that follows returns data from that same fetch. Frames in bypass mode are not answered by the bridge. Instead it raises a select, with the PHY index, for the length of the frame.

Top module: `mdio_pg_bridge`

## Requirements
- R1: A write frame whose PHY address has bits [4:3] = 3 (page mode) loads write-data bits [9:0] into the page register. The page supplies bits [18:9] of every later internal register address.
- R2: In register mode (PHY address bits [4:3] = 2), the internal byte address is {page, PHY address [2:0], register address [4:1], 2'b00}. Register address bit 0 selects the half: 0 is bits [15:0] and 1 is bits [31:16].
- R3: A low-half write produces no port write. The next high-half write produces exactly one single-cycle reg_we pulse with reg_wdata = {high data, staged low data}.
- R4: A low-half read produces exactly one single-cycle reg_re pulse. reg_rdata is taken one cycle after that pulse, and its bits [15:0] are returned on MDIO.
- R5: A high-half read returns bits [31:16] from the fetch made by the last low-half read, even if the register was written in between. It makes no port access.
- R6: A read in page mode returns 0x0000 and makes no port access. The page register cannot be read back.
- R7: In bypass mode (bits [4:3] = 0), byp_valid is high and byp_phy equals PHY address bits [2:0] from header decode to the end of the frame. The bridge never drives MDIO and makes no port access.
- R8: On a claimed read, MDIO is undriven during the first turnaround bit and driven 0 during the second. The 16 data bits then follow, most significant bit first, and the line is released after the last one.
- R9: Reset clears the page register to 0. Reset wins over a page write that completes while it is asserted.
- R10: Frames with bits [4:3] = 1 are ignored: no port access, no bypass select and no MDIO drive.
- R11: The bridge never drives MDIO during a write frame.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock; oversamples MDC |
| rst | input | 1 | Synchronous active-high reset |
| mdc | input | 1 | Management clock from the host |
| mdio_in | input | 1 | Sensed level of the MDIO line |
| mdio_out | output | 1 | Level driven onto MDIO when enabled |
| mdio_oe | output | 1 | Output enable for MDIO |
| byp_valid | output | 1 | High while a bypass frame is in progress |
| byp_phy | output | 3 | Index of the real PHY addressed by the bypass frame |
| reg_addr | output | PAGE_W+9 | Internal byte address, low two bits zero |
| reg_wdata | output | 32 | Internal write data |
| reg_we | output | 1 | Single-cycle write strobe |
| reg_re | output | 1 | Single-cycle read strobe |
| reg_rdata | input | 32 | Internal read data, valid one cycle after reg_re |

## Verification
The page-write commit and the synchronous reset can fall in the same cycle. This happens when reset is asserted just as the final data bit of a page-set frame is sampled. The bench raises reset one system clock before that last MDC rising edge and holds it across the whole sampling delay, so that the cycle in which the page would load lies inside the reset window. A following register-mode write must then carry page bits of zero in its address, which shows that reset took priority.

// File: rtl/mdio_pg_pkg.sv
package mdio_pg_pkg;

    // access modes carried in PHY address bits [4:3]
    localparam logic [1:0] MODE_BYP  = 2'd0;
    localparam logic [1:0] MODE_REG  = 2'd2;
    localparam logic [1:0] MODE_PAGE = 2'd3;

    localparam logic [1:0] OPC_RD = 2'b10;
    localparam logic [1:0] OPC_WR = 2'b01;

    localparam int HALF_W = 16;
    localparam int WORD_W = 32;
    localparam int SUB_W  = 3;

    typedef struct packed {
        logic       is_rd;
        logic [4:0] phy;
        logic [4:0] ra;
    } mdio_hdr_t;

    typedef enum logic [1:0] {
        FS_IDLE,
        FS_HDR,
        FS_TA,
        FS_DATA
    } fstate_t;

    function automatic logic [1:0] mode_of(input logic [4:0] phy);
        return phy[4:3];
    endfunction

    function automatic logic opcode_ok(input logic [1:0] opc);
        return (opc == OPC_RD) || (opc == OPC_WR);
    endfunction

endpackage

// File: rtl/mdio_pg_sync.sv
module mdio_pg_sync #(
    parameter int   STAGES  = 2,
    parameter logic RST_VAL = 1'b0
) (
    input  logic clk,
    input  logic rst,
    input  logic d,
    output logic q
);
    logic [STAGES-1:0] ff;

    for (genvar i = 0; i < STAGES; i++) begin : g_stage
        if (i == 0) begin : g_first
            always_ff @(posedge clk) begin
                if (rst) ff[0] <= RST_VAL;
                else     ff[0] <= d;
            end
        end else begin : g_next
            always_ff @(posedge clk) begin
                if (rst) ff[i] <= RST_VAL;
                else     ff[i] <= ff[i-1];
            end
        end
    end

    assign q = ff[STAGES-1];
endmodule

// File: rtl/mdio_pg_frame.sv
module mdio_pg_frame
    import mdio_pg_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              mdc_s,
    input  logic              mdio_s,
    input  logic              claim,
    input  logic [HALF_W-1:0] rd_half,
    output logic              hdr_stb,
    output mdio_hdr_t         hdr,
    output logic              wr_stb,
    output logic [HALF_W-1:0] wr_data,
    output logic              frame_end,
    output logic              mdio_out,
    output logic              mdio_oe
);
    fstate_t           state;
    logic [3:0]        cnt;
    logic [HALF_W-1:0] sh;
    logic [HALF_W-1:0] tx_sh;
    logic              mdc_d;
    logic              rise;
    logic [12:0]       hdr_bits;
    logic              answer;

    assign rise     = mdc_s & ~mdc_d;
    // second start bit, opcode, PHY address, register address
    assign hdr_bits = {sh[11:0], mdio_s};
    assign answer   = hdr.is_rd & claim;

    always_ff @(posedge clk) begin
        if (rst) begin
            state     <= FS_IDLE;
            cnt       <= '0;
            sh        <= '0;
            tx_sh     <= '0;
            mdc_d     <= 1'b0;
            hdr       <= '0;
            hdr_stb   <= 1'b0;
            wr_stb    <= 1'b0;
            wr_data   <= '0;
            frame_end <= 1'b0;
            mdio_out  <= 1'b1;
            mdio_oe   <= 1'b0;
        end else begin
            mdc_d     <= mdc_s;
            hdr_stb   <= 1'b0;
            wr_stb    <= 1'b0;
            frame_end <= 1'b0;
            if (rise) begin
                case (state)
                    FS_IDLE: begin
                        if (!mdio_s) begin
                            state <= FS_HDR;
                            cnt   <= '0;
                        end
                    end
                    FS_HDR: begin
                        sh  <= {sh[HALF_W-2:0], mdio_s};
                        cnt <= cnt + 4'd1;
                        if (cnt == 4'd12) begin
                            cnt <= '0;
                            if (hdr_bits[12] && opcode_ok(hdr_bits[11:10])) begin
                                hdr.is_rd <= (hdr_bits[11:10] == OPC_RD);
                                hdr.phy   <= hdr_bits[9:5];
                                hdr.ra    <= hdr_bits[4:0];
                                hdr_stb   <= 1'b1;
                                state     <= FS_TA;
                            end else begin
                                state <= FS_IDLE;
                            end
                        end
                    end
                    FS_TA: begin
                        cnt <= cnt + 4'd1;
                        if (cnt == 4'd0) begin
                            if (answer) begin
                                mdio_oe  <= 1'b1;
                                mdio_out <= 1'b0;
                            end
                        end else begin
                            state <= FS_DATA;
                            cnt   <= '0;
                            if (answer) begin
                                mdio_out <= rd_half[HALF_W-1];
                                tx_sh    <= {rd_half[HALF_W-2:0], 1'b0};
                            end
                        end
                    end
                    default: begin
                        sh  <= {sh[HALF_W-2:0], mdio_s};
                        cnt <= cnt + 4'd1;
                        if (answer) begin
                            mdio_out <= tx_sh[HALF_W-1];
                            tx_sh    <= {tx_sh[HALF_W-2:0], 1'b0};
                        end
                        if (cnt == 4'd15) begin
                            state     <= FS_IDLE;
                            mdio_oe   <= 1'b0;
                            mdio_out  <= 1'b1;
                            frame_end <= 1'b1;
                            if (!hdr.is_rd) begin
                                wr_stb  <= 1'b1;
                                wr_data <= {sh[HALF_W-2:0], mdio_s};
                            end
                        end
                    end
                endcase
            end
        end
    end
endmodule

// File: rtl/mdio_pg_xlate.sv
module mdio_pg_xlate
    import mdio_pg_pkg::*;
#(
    parameter int PAGE_W = 10,
    localparam int AW    = PAGE_W + SUB_W + 6
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              hdr_stb,
    input  mdio_hdr_t         hdr,
    input  logic              wr_stb,
    input  logic [HALF_W-1:0] wr_data,
    input  logic              frame_end,
    input  logic [WORD_W-1:0] reg_rdata,
    output logic              claim,
    output logic [HALF_W-1:0] rd_half,
    output logic [AW-1:0]     reg_addr,
    output logic [WORD_W-1:0] reg_wdata,
    output logic              reg_we,
    output logic              reg_re,
    output logic              byp_valid,
    output logic [SUB_W-1:0]  byp_phy,
    output logic [PAGE_W-1:0] page_o
);
    logic [PAGE_W-1:0] page_q;
    logic [HALF_W-1:0] stage_lo;
    logic [HALF_W-1:0] upper_q;
    logic              fetch_pend;
    logic [1:0]        mode;
    logic              hi_half;
    logic [AW-1:0]     word_addr;

    assign mode      = mode_of(hdr.phy);
    assign hi_half   = hdr.ra[0];
    assign claim     = (mode == MODE_REG) || (mode == MODE_PAGE);
    assign word_addr = {page_q, hdr.phy[SUB_W-1:0], hdr.ra[4:1], 2'b00};
    assign page_o    = page_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            page_q     <= '0;
            stage_lo   <= '0;
            upper_q    <= '0;
            fetch_pend <= 1'b0;
            rd_half    <= '0;
            reg_addr   <= '0;
            reg_wdata  <= '0;
            reg_we     <= 1'b0;
            reg_re     <= 1'b0;
            byp_valid  <= 1'b0;
            byp_phy    <= '0;
        end else begin
            reg_we     <= 1'b0;
            reg_re     <= 1'b0;
            fetch_pend <= reg_re;
            if (fetch_pend) begin
                rd_half <= reg_rdata[HALF_W-1:0];
                upper_q <= reg_rdata[WORD_W-1:HALF_W];
            end
            if (hdr_stb) begin
                case (mode)
                    MODE_REG: begin
                        if (hdr.is_rd) begin
                            if (hi_half) begin
                                rd_half <= upper_q;
                            end else begin
                                reg_re   <= 1'b1;
                                reg_addr <= word_addr;
                            end
                        end
                    end
                    MODE_PAGE: begin
                        if (hdr.is_rd) rd_half <= '0;
                    end
                    MODE_BYP: begin
                        byp_valid <= 1'b1;
                        byp_phy   <= hdr.phy[SUB_W-1:0];
                    end
                    default: ;
                endcase
            end
            if (wr_stb) begin
                if (mode == MODE_REG) begin
                    if (hi_half) begin
                        reg_we    <= 1'b1;
                        reg_addr  <= word_addr;
                        reg_wdata <= {wr_data, stage_lo};
                    end else begin
                        stage_lo <= wr_data;
                    end
                end else if (mode == MODE_PAGE) begin
                    page_q <= wr_data[PAGE_W-1:0];
                end
            end
            if (frame_end) byp_valid <= 1'b0;
        end
    end
endmodule

// File: rtl/mdio_pg_bridge.sv
module mdio_pg_bridge
    import mdio_pg_pkg::*;
#(
    parameter int PAGE_W      = 10,
    parameter int SYNC_STAGES = 2
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                mdc,
    input  logic                mdio_in,
    output logic                mdio_out,
    output logic                mdio_oe,
    output logic                byp_valid,
    output logic [2:0]          byp_phy,
    output logic [PAGE_W+8:0]   reg_addr,
    output logic [31:0]         reg_wdata,
    output logic                reg_we,
    output logic                reg_re,
    input  logic [31:0]         reg_rdata
);
    logic              mdc_s;
    logic              mdio_s;
    logic              claim;
    logic [HALF_W-1:0] rd_half;
    logic              hdr_stb;
    mdio_hdr_t         hdr;
    logic              wr_stb;
    logic [HALF_W-1:0] wr_data;
    logic              frame_end;
    logic [PAGE_W-1:0] page_cur;

    mdio_pg_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b0)) u_sync_mdc (
        .clk(clk), .rst(rst), .d(mdc), .q(mdc_s)
    );

    mdio_pg_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b1)) u_sync_mdio (
        .clk(clk), .rst(rst), .d(mdio_in), .q(mdio_s)
    );

    mdio_pg_frame u_frame (
        .clk(clk), .rst(rst), .mdc_s(mdc_s), .mdio_s(mdio_s),
        .claim(claim), .rd_half(rd_half),
        .hdr_stb(hdr_stb), .hdr(hdr), .wr_stb(wr_stb), .wr_data(wr_data),
        .frame_end(frame_end), .mdio_out(mdio_out), .mdio_oe(mdio_oe)
    );

    mdio_pg_xlate #(.PAGE_W(PAGE_W)) u_xlate (
        .clk(clk), .rst(rst), .hdr_stb(hdr_stb), .hdr(hdr),
        .wr_stb(wr_stb), .wr_data(wr_data), .frame_end(frame_end),
        .reg_rdata(reg_rdata), .claim(claim), .rd_half(rd_half),
        .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_we(reg_we),
        .reg_re(reg_re), .byp_valid(byp_valid), .byp_phy(byp_phy),
        .page_o(page_cur)
    );
endmodule

// File: rtl/mdio_pg_bridge_chk.sv
module mdio_pg_bridge_chk #(
    parameter int PAGE_W = 10
) (
    input logic              clk,
    input logic              rst,
    input logic              mdio_out,
    input logic              mdio_oe,
    input logic              byp_valid,
    input logic              reg_we,
    input logic              reg_re,
    input logic [PAGE_W-1:0] page
);
    a_r3_single_commit: assert property (@(posedge clk) disable iff (rst)
        reg_we |=> !reg_we);

    a_r4_single_fetch: assert property (@(posedge clk) disable iff (rst)
        reg_re |=> !reg_re);

    a_r3_we_re_apart: assert property (@(posedge clk) disable iff (rst)
        !(reg_we && reg_re));

    a_r7_bypass_silent: assert property (@(posedge clk) disable iff (rst)
        byp_valid |-> !mdio_oe);

    a_r7_bypass_no_port: assert property (@(posedge clk) disable iff (rst)
        byp_valid |-> !(reg_we || reg_re));

    a_r8_ta_zero: assert property (@(posedge clk) disable iff (rst)
        $rose(mdio_oe) |-> !mdio_out);

    a_r9_page_cleared: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (page == '0));
endmodule

bind mdio_pg_bridge mdio_pg_bridge_chk #(.PAGE_W(PAGE_W)) u_chk (
    .clk(clk), .rst(rst), .mdio_out(mdio_out), .mdio_oe(mdio_oe),
    .byp_valid(byp_valid), .reg_we(reg_we), .reg_re(reg_re),
    .page(page_cur)
);

// File: tb/tb_mdio_pg_bridge.sv
`timescale 1ns/1ps
module tb_mdio_pg_bridge;
    localparam int PAGE_W = 10;
    localparam int AW     = PAGE_W + 9;
    localparam int H      = 8;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          mdc = 1'b0;
    logic          host_oe = 1'b1;
    logic          host_bit = 1'b1;
    logic          mdio_out, mdio_oe, byp_valid;
    logic [2:0]    byp_phy;
    logic [AW-1:0] reg_addr;
    logic [31:0]   reg_wdata, reg_rdata;
    logic          reg_we, reg_re;
    logic          bus;

    int checks = 0;
    int errors = 0;
    int wr_cnt = 0;
    int rd_cnt = 0;
    int oe_cnt = 0;
    logic [AW-1:0] last_waddr;
    logic [31:0]   last_wdata;
    logic [31:0]   mem [64];
    bit done = 0;

    always #2 clk = ~clk;

    assign bus = mdio_oe ? mdio_out : (host_oe ? host_bit : 1'b1);

    mdio_pg_bridge #(.PAGE_W(PAGE_W)) dut (
        .clk(clk), .rst(rst), .mdc(mdc), .mdio_in(bus),
        .mdio_out(mdio_out), .mdio_oe(mdio_oe),
        .byp_valid(byp_valid), .byp_phy(byp_phy),
        .reg_addr(reg_addr), .reg_wdata(reg_wdata),
        .reg_we(reg_we), .reg_re(reg_re), .reg_rdata(reg_rdata)
    );

    function automatic logic [31:0] init_word(input int i);
        return 32'hA500_0000 | (i * 32'h0001_0101);
    endfunction

    function automatic logic [AW-1:0] mk_addr(input int page, input int sub, input int pair);
        return AW'((page << 9) | (sub << 6) | (pair << 2));
    endfunction

    initial begin
        for (int i = 0; i < 64; i++) mem[i] = init_word(i);
    end

    // register port model: read data one cycle after reg_re
    always @(posedge clk) begin
        if (reg_re) begin
            reg_rdata <= mem[reg_addr[7:2]];
            rd_cnt    <= rd_cnt + 1;
        end
        if (reg_we) begin
            mem[reg_addr[7:2]] <= reg_wdata;
            last_waddr <= reg_addr;
            last_wdata <= reg_wdata;
            wr_cnt     <= wr_cnt + 1;
        end
    end

    always @(negedge clk) if (mdio_oe) oe_cnt <= oe_cnt + 1;

    task automatic check(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual %h expected %h", tag, act, exp);
        end
    endtask

    task automatic one_bit(input bit drv, input bit val, input bit rst_edge,
                           output bit smp, output bit oe_s);
        host_oe  = drv;
        host_bit = val;
        repeat (H - 1) @(negedge clk);
        if (rst_edge) rst = 1'b1;
        @(negedge clk);
        smp  = bus;
        oe_s = mdio_oe;
        mdc  = 1'b1;
        repeat (H) @(negedge clk);
        mdc = 1'b0;
        if (rst_edge) rst = 1'b0;
    endtask

    task automatic frame(input bit rd, input logic [4:0] phy, input logic [4:0] ra,
                         input logic [15:0] wd, input bit rst_end,
                         output logic [15:0] rdat, output bit ta1_oe, output bit ta2_bus,
                         output bit bv, output logic [2:0] bp);
        bit s, o;
        logic [12:0] hb;
        hb = {1'b1, (rd ? 2'b10 : 2'b01), phy, ra};
        for (int i = 0; i < 8; i++) one_bit(1, 1, 0, s, o);
        one_bit(1, 0, 0, s, o);
        for (int i = 12; i >= 0; i--) one_bit(1, hb[i], 0, s, o);
        if (rd) begin
            one_bit(0, 1, 0, s, o);
            ta1_oe = o;
            bv = byp_valid;
            bp = byp_phy;
            one_bit(0, 1, 0, s, o);
            ta2_bus = s;
            for (int i = 15; i >= 0; i--) begin
                one_bit(0, 1, 0, s, o);
                rdat[i] = s;
            end
        end else begin
            one_bit(1, 1, 0, s, o);
            ta1_oe = o;
            bv = byp_valid;
            bp = byp_phy;
            one_bit(1, 0, 0, s, o);
            ta2_bus = s;
            for (int i = 15; i >= 0; i--) one_bit(1, wd[i], (i == 0) && rst_end, s, o);
            rdat = '0;
        end
        one_bit(1, 1, 0, s, o);
        one_bit(1, 1, 0, s, o);
    endtask

    task automatic wr16(input logic [4:0] phy, input logic [4:0] ra, input logic [15:0] wd);
        logic [15:0] r; bit a, b, c; logic [2:0] p;
        frame(0, phy, ra, wd, 0, r, a, b, c, p);
    endtask

    task automatic rd16(input logic [4:0] phy, input logic [4:0] ra, output logic [15:0] r);
        bit a, b, c; logic [2:0] p;
        frame(1, phy, ra, 16'h0, 0, r, a, b, c, p);
    endtask

    task automatic t_reset_state;
        check(!mdio_oe && !reg_we && !reg_re && !byp_valid, "R9 reset idle outputs",
              {mdio_oe, reg_we, reg_re, byp_valid}, 0);
    endtask

    task automatic t_paged_write;
        int w0, o0;
        w0 = wr_cnt; o0 = oe_cnt;
        wr16(5'b11000, 5'd0, 16'h02A5);
        wr16(5'b10101, 5'd12, 16'h0B1E);
        check(wr_cnt == w0, "R3 low half only staged", wr_cnt, w0);
        wr16(5'b10101, 5'd13, 16'hCAFE);
        check(wr_cnt == w0 + 1, "R3 one commit on high half", wr_cnt, w0 + 1);
        check(last_waddr == mk_addr(10'h2A5, 5, 6), "R1 R2 commit address",
              last_waddr, mk_addr(10'h2A5, 5, 6));
        check(last_wdata == 32'hCAFE0B1E, "R3 commit data", last_wdata, 32'hCAFE0B1E);
        check(oe_cnt == o0, "R11 no drive in writes", oe_cnt, o0);
    endtask

    task automatic t_paged_read;
        logic [15:0] r; bit a, b, c; logic [2:0] p; int r0;
        r0 = rd_cnt;
        frame(1, 5'b10101, 5'd12, 16'h0, 0, r, a, b, c, p);
        check(r == 16'h0B1E, "R4 low half data", r, 16'h0B1E);
        check(rd_cnt == r0 + 1, "R4 one fetch", rd_cnt, r0 + 1);
        check(!a && !b, "R8 turnaround Z then 0", {a, b}, 0);
        rd16(5'b10101, 5'd13, r);
        check(r == 16'hCAFE, "R5 high half data", r, 16'hCAFE);
        check(rd_cnt == r0 + 1, "R5 no fetch on high half", rd_cnt, r0 + 1);
    endtask

    task automatic t_stale_latch;
        logic [15:0] r; logic [31:0] old;
        old = init_word(6'h2A);
        rd16(5'b10010, 5'd20, r);
        check(r == old[15:0], "R4 initial low half", r, old[15:0]);
        wr16(5'b10010, 5'd20, 16'h5678);
        wr16(5'b10010, 5'd21, 16'h1234);
        rd16(5'b10010, 5'd21, r);
        check(r == old[31:16], "R5 high half from same fetch", r, old[31:16]);
        rd16(5'b10010, 5'd20, r);
        check(r == 16'h5678, "R4 fresh low half", r, 16'h5678);
        rd16(5'b10010, 5'd21, r);
        check(r == 16'h1234, "R5 fresh high half", r, 16'h1234);
    endtask

    task automatic t_page_read;
        logic [15:0] r; bit a, b, c; logic [2:0] p; int r0;
        r0 = rd_cnt;
        frame(1, 5'b11000, 5'd0, 16'h0, 0, r, a, b, c, p);
        check(r == 16'h0000, "R6 page reads as zero", r, 0);
        check(rd_cnt == r0, "R6 no fetch", rd_cnt, r0);
        check(!a && !b, "R8 turnaround on page read", {a, b}, 0);
    endtask

    task automatic t_bypass;
        logic [15:0] r; bit a, b, c; logic [2:0] p; int r0, w0, o0;
        r0 = rd_cnt; w0 = wr_cnt; o0 = oe_cnt;
        frame(1, 5'b00011, 5'd2, 16'h0, 0, r, a, b, c, p);
        check(c && p == 3'd3, "R7 bypass select on read", {c, p}, {1'b1, 3'd3});
        frame(0, 5'b00110, 5'd4, 16'hFFFF, 0, r, a, b, c, p);
        check(c && p == 3'd6, "R7 bypass select on write", {c, p}, {1'b1, 3'd6});
        check(!byp_valid, "R7 select drops at frame end", byp_valid, 0);
        check(oe_cnt == o0 && rd_cnt == r0 && wr_cnt == w0, "R7 silent and no port access",
              oe_cnt - o0 + rd_cnt - r0 + wr_cnt - w0, 0);
    endtask

    task automatic t_mode_one;
        logic [15:0] r; bit a, b, c; logic [2:0] p; int r0, w0, o0;
        r0 = rd_cnt; w0 = wr_cnt; o0 = oe_cnt;
        frame(0, 5'b01101, 5'd1, 16'h4321, 0, r, a, b, c, p);
        frame(1, 5'b01101, 5'd0, 16'h0, 0, r, a, b, c, p);
        check(!c, "R10 no bypass select", c, 0);
        check(oe_cnt == o0 && rd_cnt == r0 && wr_cnt == w0, "R10 frames ignored",
              oe_cnt - o0 + rd_cnt - r0 + wr_cnt - w0, 0);
    endtask

    task automatic t_reset_clears_page;
        wr16(5'b11000, 5'd0, 16'h0155);
        @(negedge clk); rst = 1'b1;
        repeat (3) @(negedge clk); rst = 1'b0;
        wr16(5'b10111, 5'd30, 16'h1111);
        wr16(5'b10111, 5'd31, 16'h2222);
        check(last_waddr == mk_addr(0, 7, 15), "R9 page zero after reset",
              last_waddr, mk_addr(0, 7, 15));
    endtask

    task automatic t_reset_races_page_write;
        logic [15:0] r; bit a, b, c; logic [2:0] p;
        frame(0, 5'b11000, 5'd0, 16'h03FF, 1, r, a, b, c, p);
        wr16(5'b10000, 5'd2, 16'hAAAA);
        wr16(5'b10000, 5'd3, 16'hBBBB);
        check(last_waddr == mk_addr(0, 0, 1), "R9 reset beats page write",
              last_waddr, mk_addr(0, 0, 1));
        wr16(5'b11000, 5'd0, 16'h03FF);
        wr16(5'b10000, 5'd2, 16'hCCCC);
        wr16(5'b10000, 5'd3, 16'hDDDD);
        check(last_waddr == mk_addr(10'h3FF, 0, 1), "R1 full page value",
              last_waddr, mk_addr(10'h3FF, 0, 1));
        check(last_wdata == 32'hDDDDCCCC, "R3 commit data after page change",
              last_wdata, 32'hDDDDCCCC);
    endtask

    initial begin
        repeat (5) @(negedge clk);
        t_reset_state();
        rst = 1'b0;
        repeat (4) @(negedge clk);
        t_paged_write();
        t_paged_read();
        t_stale_latch();
        t_page_read();
        t_bypass();
        t_mode_one();
        t_reset_clears_page();
        t_reset_races_page_write();
        done = 1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog expired actual %0d expected %0d", 0, 1);
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end
endmodule